// File: doc/BRIEF.md
# Serial Port Control and Status Register Block

This block is the software-visible register file of a simple serial port. A word-addressed bus port reads and writes control, status, baud and timing registers. A one-character holding buffer takes received bytes from a byte-valid input, and a ready output pushes back while the buffer holds an unread character. A break input loads a break-marked value through the same path. Writing the transmit data offset sends the low byte out on a one-cycle strobe, but only when transmit is enabled.

Reading the receive data offset has a side effect: it consumes the buffered character. Writing the soft-reset bit of control register 2 as zero returns the block to its defaults. The interrupt output merges receive-ready and transmit-ready with their enables. The transmit-ready term only counts while a separate transmit-empty enable is set. Serial bit timing and baud generation lie outside this block, so the baud and timing registers only store what is written and return it on a read.

Top module: `serial_csr_block`

## Requirements
- R1: After hardware reset the registers read as follows: status 1 (0x25) 0x6040, status 2 (0x26) 0x4028, test (0x2D) 0x0060, control 1 (0x20) 0x0000, control 2 (0x21) 0x0001, control 3 (0x22) 0x0700, modulator (0x2A) 0x0000, baud count (0x2B) 0x0004, FIFO control (0x24) and millisecond (0x2C) 0x0000. Receive data (0x00) reads 0x4000 (bit 14 = error), rx_ready is 1, and irq and tx_strobe are 0.
- R2: Writes to control 1, control 3, FIFO control, modulator and millisecond keep only bits 15:0 of the written word, and the value reads back at the same offset.
- R3: A byte is taken when rx_valid and rx_ready are both high. Taking it sets status 1 bit 9 and status 2 bit 0, clears test bit 5 (RX-empty), stores the byte in buffer bits 7:0 with bits 15:8 zero, and drops rx_ready.
- R4: A read of offset 0x00 while a character is held returns the buffer with bit 15 (char-ready) set. The same read clears status 1 bit 9 and status 2 bit 0 and sets test bit 5. A read while empty returns the buffer without bit 15 and changes nothing.
- R5: While a character is held, rx_valid is ignored and the buffer keeps its contents.
- R6: A break pulse loads the buffer with 0x0800 (bit 11 = break) and marks it held. It does this even if a character is already held, and it wins over a byte offered in the same cycle.
- R7: A write to 0x10 while control 2 bit 2 (transmit enable) is set raises tx_strobe for exactly one cycle, in the cycle after the write, with tx_byte equal to bits 7:0 of the write. Without the enable no strobe occurs. Status 1 bit 13 (transmit-ready) stays 1.
- R8: Writes to status 1 and status 2 only clear event bits where a 1 is written (status 1 mask 0x9DB0, status 2 mask 0xBFD6). Transmit-ready, receive-ready, RTS status, receiver status, transmit-empty, transmit-done, DCD-in and receive-data-ready are unaffected.
- R9: A write to control 2 with bit 0 equal to 0 restores every R1 default except FIFO control and millisecond, which keep their values. It also drops any held character. Control 2 then holds the written bits 15:0 with bit 0 forced to 1.
- R10: irq is high when status 1 bit 9 and control 1 bit 9 are both set, or when control 1 bit 6 (transmit-empty enable) is set and test bit 6 is set, or when control 1 bits 6 and 13 and status 1 bit 13 are all set. Otherwise irq is low.
- R11: Writes to control 4 (0x23), the test register (0x2D) and baud count (0x2B) are ignored. A write to baud increment (0x29) updates the value read at 0x2B. Offsets 0x23, 0x29 and every undefined offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current offset, combinational |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Buffer can take a byte |
| brk_event | input | 1 | Line break detected, one-cycle pulse |
| tx_strobe | output | 1 | Transmit byte valid for one cycle |
| tx_byte | output | BYTE_W | Byte to send |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume the bus never issues a read and a write in the same cycle. They also assume brk_event and rx_valid are sampled as plain synchronous levels, so the buffer and status properties only reason about one bus operation per edge. The directed bench drives every input on the falling edge and holds each bus strobe for exactly one cycle. It never raises both strobes together and offers bytes only through single-cycle pulses. The receive-consume and soft-reset properties therefore see the one-operation traffic they were written for.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

    localparam int unsigned REG_W = 16;
    typedef logic [REG_W-1:0] reg16_t;

    // word offsets
    localparam logic [5:0] OFS_RXD   = 6'h00;
    localparam logic [5:0] OFS_TXD   = 6'h10;
    localparam logic [5:0] OFS_CTL1  = 6'h20;
    localparam logic [5:0] OFS_CTL2  = 6'h21;
    localparam logic [5:0] OFS_CTL3  = 6'h22;
    localparam logic [5:0] OFS_CTL4  = 6'h23;
    localparam logic [5:0] OFS_FIFO  = 6'h24;
    localparam logic [5:0] OFS_STAT1 = 6'h25;
    localparam logic [5:0] OFS_STAT2 = 6'h26;
    localparam logic [5:0] OFS_BINC  = 6'h29;
    localparam logic [5:0] OFS_BMOD  = 6'h2A;
    localparam logic [5:0] OFS_BCNT  = 6'h2B;
    localparam logic [5:0] OFS_MSEC  = 6'h2C;
    localparam logic [5:0] OFS_TEST  = 6'h2D;

    // control bits
    localparam int unsigned C1_TXE_EN  = 6;
    localparam int unsigned C1_RRDY_EN = 9;
    localparam int unsigned C1_TRDY_EN = 13;
    localparam int unsigned C2_SRST    = 0;
    localparam int unsigned C2_TXEN    = 2;

    // status bits
    localparam int unsigned S1_RRDY    = 9;
    localparam int unsigned S1_TRDY    = 13;
    localparam int unsigned S2_RDR     = 0;
    localparam int unsigned T_RXEMPTY  = 5;
    localparam int unsigned T_TXEMPTY  = 6;

    // buffer flags
    localparam int unsigned B_CHARRDY  = 15;
    localparam int unsigned B_ERR      = 14;
    localparam int unsigned B_BRK      = 11;

    localparam reg16_t S1_EVT_MASK = 16'h9DB0;
    localparam reg16_t S2_EVT_MASK = 16'hBFD6;

    localparam reg16_t BUF_DEFAULT = reg16_t'(1) << B_ERR;
    localparam reg16_t BUF_BREAK   = reg16_t'(1) << B_BRK;

    typedef struct packed {
        reg16_t ctl1;
        reg16_t ctl2;
        reg16_t ctl3;
        reg16_t fifo;
        reg16_t bmod;
        reg16_t bcnt;
        reg16_t msec;
        reg16_t stat1;   // receive-ready inserted from the buffer
        reg16_t stat2;   // receive-data-ready inserted from the buffer
        reg16_t test;    // rx-empty inserted from the buffer
    } csr_regs_t;

    function automatic csr_regs_t csr_defaults(input reg16_t keep_fifo, input reg16_t keep_msec);
        csr_regs_t r;
        r.ctl1  = 16'h0000;
        r.ctl2  = 16'h0001;
        r.ctl3  = 16'h0700;
        r.fifo  = keep_fifo;
        r.bmod  = 16'h0000;
        r.bcnt  = 16'h0004;
        r.msec  = keep_msec;
        r.stat1 = 16'h6040;
        r.stat2 = 16'h4028;
        r.test  = 16'h0040;
        return r;
    endfunction

endpackage

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import serial_csr_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push_valid,
    input  logic [BYTE_W-1:0] push_byte,
    input  logic              brk,
    input  logic              consume,
    output logic              ready,
    output logic              full,
    output reg16_t            word
);

    typedef struct packed {
        logic   full;
        reg16_t data;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (consume && st_q.full) begin
            st_d.full = 1'b0;
        end
        if (push_valid && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = reg16_t'(push_byte);
        end
        if (brk) begin
            st_d.full = 1'b1;
            st_d.data = BUF_BREAK;
        end
        if (clr) begin
            st_d.full = 1'b0;
            st_d.data = BUF_DEFAULT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{full: 1'b0, data: BUF_DEFAULT};
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = !st_q.full;
    assign full  = st_q.full;
    assign word  = st_q.data;

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && ready && !clr) |=> full); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !consume && !brk && !clr) |=> (full && $stable(word))); // R5

    AST_CONSUME_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && full && !brk && !clr) |=> !full); // R4

    AST_BRK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (brk && !clr) |=> (full && word[B_BRK])); // R6

endmodule

// File: rtl/serial_tx_emit.sv
module serial_tx_emit #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [BYTE_W-1:0] fire_byte,
    output logic              strobe,
    output logic [BYTE_W-1:0] byte_out
);

    typedef struct packed {
        logic              stb;
        logic [BYTE_W-1:0] dat;
    } emit_t;

    emit_t em_d, em_q;

    always_comb begin
        em_d     = em_q;
        em_d.stb = fire;
        if (fire) begin
            em_d.dat = fire_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_q <= '0;
        end else begin
            em_q <= em_d;
        end
    end

    assign strobe   = em_q.stb;
    assign byte_out = em_q.dat;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !fire) |=> !strobe); // R7

endmodule

// File: rtl/serial_irq_merge.sv
module serial_irq_merge
    import serial_csr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  reg16_t stat1_view,
    input  reg16_t ctl1,
    input  logic   tx_empty,
    output logic   irq
);

    localparam reg16_t SRC_MASK = (reg16_t'(1) << S1_TRDY) | (reg16_t'(1) << S1_RRDY);

    reg16_t flags;
    logic   txe_term;

    always_comb begin
        flags    = stat1_view & ctl1 & SRC_MASK;
        txe_term = 1'b0;
        if (ctl1[C1_TXE_EN]) begin
            txe_term = tx_empty;
        end else begin
            flags[S1_TRDY] = 1'b0;
        end
        irq = (|flags) | txe_term;
    end

    AST_IRQ_RX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat1_view[S1_RRDY] && ctl1[C1_RRDY_EN]) |-> irq); // R10

    AST_IRQ_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl1[C1_TXE_EN] && !(stat1_view[S1_RRDY] && ctl1[C1_RRDY_EN])) |-> !irq); // R10

endmodule

// File: rtl/serial_csr_block.sv
module serial_csr_block
    import serial_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_ready,
    input  logic              brk_event,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    localparam int unsigned LOW_W = (DATA_W < REG_W) ? DATA_W : REG_W;

    csr_regs_t regs_d, regs_q;

    reg16_t wlow;
    logic   soft_rst;
    logic   consume;
    logic   tx_fire;
    logic   buf_full;
    reg16_t buf_word;
    reg16_t stat1_view;
    reg16_t stat2_view;
    reg16_t test_view;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [5:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign wlow     = reg16_t'(bus_wdata[LOW_W-1:0]);
    assign soft_rst = bus_wr_en && hit(bus_addr, OFS_CTL2) && !wlow[C2_SRST];
    assign consume  = bus_rd_en && hit(bus_addr, OFS_RXD);
    assign tx_fire  = bus_wr_en && hit(bus_addr, OFS_TXD) && regs_q.ctl2[C2_TXEN];

    always_comb begin
        regs_d = regs_q;
        if (bus_wr_en) begin
            if (hit(bus_addr, OFS_CTL1)) begin
                regs_d.ctl1 = wlow;
            end else if (hit(bus_addr, OFS_CTL2)) begin
                if (!wlow[C2_SRST]) begin
                    regs_d = csr_defaults(regs_q.fifo, regs_q.msec);
                end
                regs_d.ctl2 = wlow | (reg16_t'(1) << C2_SRST);
            end else if (hit(bus_addr, OFS_CTL3)) begin
                regs_d.ctl3 = wlow;
            end else if (hit(bus_addr, OFS_FIFO)) begin
                regs_d.fifo = wlow;
            end else if (hit(bus_addr, OFS_BINC)) begin
                regs_d.bcnt = wlow;
            end else if (hit(bus_addr, OFS_BMOD)) begin
                regs_d.bmod = wlow;
            end else if (hit(bus_addr, OFS_MSEC)) begin
                regs_d.msec = wlow;
            end else if (hit(bus_addr, OFS_STAT1)) begin
                regs_d.stat1 = regs_q.stat1 & ~(wlow & S1_EVT_MASK);
            end else if (hit(bus_addr, OFS_STAT2)) begin
                regs_d.stat2 = regs_q.stat2 & ~(wlow & S2_EVT_MASK);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= csr_defaults(16'h0000, 16'h0000);
        end else begin
            regs_q <= regs_d;
        end
    end

    serial_rx_hold #(.BYTE_W(BYTE_W)) u_rx_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (soft_rst),
        .push_valid (rx_valid),
        .push_byte  (rx_byte),
        .brk        (brk_event),
        .consume    (consume),
        .ready      (rx_ready),
        .full       (buf_full),
        .word       (buf_word)
    );

    serial_tx_emit #(.BYTE_W(BYTE_W)) u_tx_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (tx_fire),
        .fire_byte (bus_wdata[BYTE_W-1:0]),
        .strobe    (tx_strobe),
        .byte_out  (tx_byte)
    );

    always_comb begin
        stat1_view = regs_q.stat1;
        stat1_view[S1_RRDY] = buf_full;
        stat2_view = regs_q.stat2;
        stat2_view[S2_RDR] = buf_full;
        test_view = regs_q.test;
        test_view[T_RXEMPTY] = !buf_full;
    end

    serial_irq_merge u_irq_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat1_view (stat1_view),
        .ctl1       (regs_q.ctl1),
        .tx_empty   (test_view[T_TXEMPTY]),
        .irq        (irq)
    );

    always_comb begin
        reg16_t rv;
        rv = '0;
        if (hit(bus_addr, OFS_RXD)) begin
            rv = buf_word;
            rv[B_CHARRDY] = buf_full;
        end else if (hit(bus_addr, OFS_CTL1)) begin
            rv = regs_q.ctl1;
        end else if (hit(bus_addr, OFS_CTL2)) begin
            rv = regs_q.ctl2;
        end else if (hit(bus_addr, OFS_CTL3)) begin
            rv = regs_q.ctl3;
        end else if (hit(bus_addr, OFS_FIFO)) begin
            rv = regs_q.fifo;
        end else if (hit(bus_addr, OFS_STAT1)) begin
            rv = stat1_view;
        end else if (hit(bus_addr, OFS_STAT2)) begin
            rv = stat2_view;
        end else if (hit(bus_addr, OFS_BMOD)) begin
            rv = regs_q.bmod;
        end else if (hit(bus_addr, OFS_BCNT)) begin
            rv = regs_q.bcnt;
        end else if (hit(bus_addr, OFS_MSEC)) begin
            rv = regs_q.msec;
        end else if (hit(bus_addr, OFS_TEST)) begin
            rv = test_view;
        end
        bus_rdata = DATA_W'(rv);
    end

    AST_ONE_BUS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_rd_en)); // R4

    AST_SRST_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit(bus_addr, OFS_CTL2)) |=> regs_q.ctl2[C2_SRST]); // R9

    AST_TRDY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        stat1_view[S1_TRDY]); // R7

    AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && hit(bus_addr, OFS_TXD) && !regs_q.ctl2[C2_TXEN]) |=> !tx_strobe); // R7

endmodule

// File: tb/serial_csr_block_test.sv
`timescale 1ns/1ps
module serial_csr_block_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_ready;
    logic        brk_event = 1'b0;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    serial_csr_block uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
        .brk_event(brk_event), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 rx_ready", 32'(rx_ready), 1);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 tx_strobe", 32'(tx_strobe), 0);
        rd_chk("R1 stat1", 6'h25, 32'h6040);
        rd_chk("R1 stat2", 6'h26, 32'h4028);
        rd_chk("R1 test", 6'h2D, 32'h0060);
        rd_chk("R1 ctl1", 6'h20, 32'h0000);
        rd_chk("R1 ctl2", 6'h21, 32'h0001);
        rd_chk("R1 ctl3", 6'h22, 32'h0700);
        rd_chk("R1 bmod", 6'h2A, 32'h0000);
        rd_chk("R1 bcnt", 6'h2B, 32'h0004);
        rd_chk("R1 fifo", 6'h24, 32'h0000);
        rd_chk("R1 msec", 6'h2C, 32'h0000);
        rd_chk("R1 rxd", 6'h00, 32'h4000);
    endtask

    task automatic t_width();
        wr(6'h20, 32'hABCD_1234); rd_chk("R2 ctl1", 6'h20, 32'h1234);
        wr(6'h22, 32'h0001_8001); rd_chk("R2 ctl3", 6'h22, 32'h8001);
        wr(6'h24, 32'h1234_5678); rd_chk("R2 fifo", 6'h24, 32'h5678);
        wr(6'h2A, 32'hFFFF_0055); rd_chk("R2 bmod", 6'h2A, 32'h0055);
        wr(6'h2C, 32'h8000_03E8); rd_chk("R2 msec", 6'h2C, 32'h03E8);
        wr(6'h29, 32'h0002_0033);
        rd_chk("R11 bcnt via increment", 6'h2B, 32'h0033);
        rd_chk("R11 increment reads zero", 6'h29, 32'h0);
        wr(6'h20, 32'h0);
    endtask

    task automatic t_rx();
        push(8'hA5);
        chk("R3 ready low", 32'(rx_ready), 0);
        rd_chk("R3 stat1", 6'h25, 32'h6240);
        rd_chk("R3 stat2", 6'h26, 32'h4029);
        rd_chk("R3 test", 6'h2D, 32'h0040);
        rd_chk("R4 consume read", 6'h00, 32'h80A5);
        rd_chk("R4 stat1 after", 6'h25, 32'h6040);
        rd_chk("R4 stat2 after", 6'h26, 32'h4028);
        rd_chk("R4 test after", 6'h2D, 32'h0060);
        chk("R4 ready back", 32'(rx_ready), 1);
        rd_chk("R4 empty read", 6'h00, 32'h00A5);
    endtask

    task automatic t_backpressure();
        push(8'h11);
        push(8'h22);
        chk("R5 ready low", 32'(rx_ready), 0);
        rd_chk("R5 first kept", 6'h00, 32'h8011);
        chk("R5 ready after", 32'(rx_ready), 1);
    endtask

    task automatic t_break();
        push(8'h33);
        @(negedge clk);
        brk_event = 1'b1; rx_valid = 1'b1; rx_byte = 8'h77;
        @(negedge clk);
        brk_event = 1'b0; rx_valid = 1'b0;
        rd_chk("R6 break over held", 6'h00, 32'h8800);
        rd_chk("R6 empty break value", 6'h00, 32'h0800);
        @(negedge clk);
        brk_event = 1'b1; rx_valid = 1'b1; rx_byte = 8'h44;
        @(negedge clk);
        brk_event = 1'b0; rx_valid = 1'b0;
        rd_chk("R6 break wins same cycle", 6'h00, 32'h8800);
    endtask

    task automatic t_tx();
        wr(6'h10, 32'h0000_01C3);
        chk("R7 no strobe disabled", 32'(tx_strobe), 0);
        wr(6'h21, 32'h0000_0005);
        wr(6'h10, 32'h0000_FFC3);
        chk("R7 strobe", 32'(tx_strobe), 1);
        chk("R7 byte", 32'(tx_byte), 32'hC3);
        @(negedge clk);
        chk("R7 strobe one cycle", 32'(tx_strobe), 0);
        rd_chk("R7 trdy kept", 6'h25, 32'h6040);
        wr(6'h21, 32'h0000_0001);
    endtask

    task automatic t_w1c();
        wr(6'h25, 32'hFFFF_FFFF);
        rd_chk("R8 stat1 empty", 6'h25, 32'h6040);
        push(8'h44);
        wr(6'h25, 32'h0000_FFFF);
        rd_chk("R8 stat1 held", 6'h25, 32'h6240);
        wr(6'h26, 32'h0000_FFFF);
        rd_chk("R8 stat2 held", 6'h26, 32'h4029);
        rd_chk("R8 byte intact", 6'h00, 32'h8044);
    endtask

    task automatic t_ignored();
        wr(6'h23, 32'hFFFF);
        rd_chk("R11 ctl4 zero", 6'h23, 32'h0);
        wr(6'h2D, 32'h0);
        rd_chk("R11 test unchanged", 6'h2D, 32'h0060);
        wr(6'h2B, 32'h0099);
        rd_chk("R11 bcnt unchanged", 6'h2B, 32'h0033);
        rd_chk("R11 undefined 3F", 6'h3F, 32'h0);
        rd_chk("R11 undefined 05", 6'h05, 32'h0);
    endtask

    task automatic t_irq();
        wr(6'h20, 32'h0200);
        chk("R10 rx enable empty", 32'(irq), 0);
        push(8'h5A);
        chk("R10 rx source", 32'(irq), 1);
        rd_chk("R10 consume", 6'h00, 32'h805A);
        chk("R10 rx cleared", 32'(irq), 0);
        wr(6'h20, 32'h2000);
        chk("R10 trdy gated", 32'(irq), 0);
        wr(6'h20, 32'h2040);
        chk("R10 trdy with txe", 32'(irq), 1);
        wr(6'h20, 32'h0040);
        chk("R10 txe only", 32'(irq), 1);
        wr(6'h20, 32'h0000);
        chk("R10 all off", 32'(irq), 0);
    endtask

    task automatic t_srst();
        wr(6'h20, 32'h0201);
        wr(6'h22, 32'h1234);
        wr(6'h2A, 32'h0055);
        wr(6'h29, 32'h0077);
        wr(6'h24, 32'h0ABC);
        wr(6'h2C, 32'h0123);
        push(8'h66);
        chk("R9 irq before", 32'(irq), 1);
        wr(6'h21, 32'h0001_0006);
        chk("R9 irq after", 32'(irq), 0);
        chk("R9 ready after", 32'(rx_ready), 1);
        rd_chk("R9 ctl2 forced", 6'h21, 32'h0007);
        rd_chk("R9 ctl1", 6'h20, 32'h0000);
        rd_chk("R9 ctl3", 6'h22, 32'h0700);
        rd_chk("R9 bmod", 6'h2A, 32'h0000);
        rd_chk("R9 bcnt", 6'h2B, 32'h0004);
        rd_chk("R9 rxd", 6'h00, 32'h4000);
        rd_chk("R9 stat1", 6'h25, 32'h6040);
        rd_chk("R9 test", 6'h2D, 32'h0060);
        rd_chk("R9 fifo kept", 6'h24, 32'h0ABC);
        rd_chk("R9 msec kept", 6'h2C, 32'h0123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_width();
        t_rx();
        t_backpressure();
        t_break();
        t_tx();
        t_w1c();
        t_ignored();
        t_irq();
        t_srst();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule